// File: doc/BRIEF.md
# Timestamped Event Lane Distributor

This block takes timestamped output events from one submitter and places each event into one of several parallel in-order queues, called lanes. Each event carries a timestamp, a channel number, an address and a data word. As it stores an event, the block adds a running sequence number to it. A later sorting stage can then resolve events that share a timestamp by taking the newest one.

The choice of lane follows the timestamp order. The block keeps writing to the current lane while timestamps rise strictly. When the timeline is rewound, meaning the timestamp is equal to or lower than the previous one, it moves to the next lane, wrapping from the last lane to the first. An optional spread mode also moves to the next lane when the current lane is full. If the target lane already holds a later timestamp, the event cannot be stored in order. The block then consumes the event, discards it and raises a sticky error flag. If the target lane is full, the submitter is held off through the valid/ready handshake, and no event is lost.

Each lane is a small synchronous queue. Its head word, level and not-empty flag are visible at the block's edge, and a downstream stage drains it with a per-lane pop.

Top module: `evlane_dist`

## Requirements
- R1: After reset, all lanes are empty with level 0, the error flag is low, lane 0 is current, and the previous timestamp, the per-lane last timestamps and the sequence counter are all 0.
- R2: Suppose an event's timestamp is strictly greater than that of the last stored event, and the current lane is not full (or spread mode is off). The event is then written to the current lane.
- R3: Suppose an event's timestamp is equal to or lower than that of the last stored event. The target becomes the next lane, and lane N-1 is followed by lane 0. A stored event makes that lane current.
- R4: With the SPREAD parameter set to 1, an event with a rising timestamp is also sent to the next lane when the current lane is full.
- R5: Suppose the target lane is not empty and the last timestamp written to it is greater than the event's timestamp. The event is then accepted with in_ready high but not stored. The error flag is set, and the current lane, the previous timestamp and the sequence counter are left unchanged.
- R6: When the target lane is full and R5 does not apply, in_ready is low and nothing is stored. The same event is stored once its target lane has room.
- R7: Stored events carry sequence numbers that start at 0 and rise by one per stored event, modulo 2^SEQ_W. SEQ_W equals the bits needed to count N_LANES*DEPTH, plus 2.
- R8: The error flag stays set until err_clr is high. If an error and err_clr occur in the same cycle, the flag stays set.
- R9: Each lane returns its events in write order. The head word is packed as {seq, chan, addr, ts, data}, with seq in the top bits and data in the bottom bits. lane_pop[i] removes the head of lane i. A pop on an empty lane is ignored. The level shows the entry count, and not-empty is high whenever the level is above 0.
- R10: When the target lane is both full and holds a later timestamp, the error of R5 takes priority. The event is consumed rather than stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Submitter presents an event |
| in_ready | output | 1 | Event is taken at this clock edge (stored or rejected) |
| in_ts | input | TS_W | Event timestamp |
| in_chan | input | CH_W | Event channel number |
| in_addr | input | AD_W | Event address |
| in_data | input | DT_W | Event data |
| err_clr | input | 1 | Clears the sticky sequence error |
| seq_err | output | 1 | Sticky sequence error flag |
| lane_pop | input | N_LANES | Per-lane pop request |
| lane_nempty | output | N_LANES | Per-lane not-empty flag |
| lane_level | output | N_LANES*LVL_W | Per-lane entry count, lane i at bits i*LVL_W upward |
| lane_head | output | N_LANES*ENT_W | Per-lane head word, lane i at bits i*ENT_W upward |

## Verification
Two pairs of events can fall in the same cycle. In the first, a rewound event targets a lane that is both full and holds a later timestamp; the bench gets there by draining lanes slowly while timestamps wander up and down. A reference model confirms that in_ready stays high, that the flag rises and that no level changes. In the second, a new sequence error and an err_clr pulse arrive together; random clear pulses cover this, and the model expects the flag to survive. Every pop is compared with the model's queue head, which checks lane choice, sequence numbering and ordering at once.

// File: rtl/evlane_pkg.sv
package evlane_pkg;

  typedef enum logic [1:0] {
    SEL_STORE  = 2'd0,
    SEL_STALL  = 2'd1,
    SEL_REJECT = 2'd2
  } sel_e;

  // bits to count the combined lane capacity, plus two bits of wrap margin
  function automatic int seq_bits(input int lanes, input int depth);
    return $clog2(lanes * depth + 1) + 2;
  endfunction

endpackage

// File: rtl/evlane_fifo.sv
module evlane_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic             full,
  output logic             nempty,
  output logic [LVL_W-1:0] level
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             push_e, pop_e;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    push_e = push && (int'(lvl_q) != DEPTH);
    pop_e  = pop && (lvl_q != '0);
    wp_d   = push_e ? bump(wp_q) : wp_q;
    rp_d   = pop_e ? bump(rp_q) : rp_q;
    lvl_d  = lvl_q;
    if (push_e && !pop_e) lvl_d = lvl_q + LVL_W'(1);
    if (pop_e && !push_e) lvl_d = lvl_q - LVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_e) mem[wp_q] <= wdata;
  end

  assign rdata  = mem[rp_q];
  assign full   = (int'(lvl_q) == DEPTH);
  assign nempty = (lvl_q != '0);
  assign level  = lvl_q;

endmodule

// File: rtl/evlane_sel.sv
module evlane_sel
  import evlane_pkg::*;
#(
  parameter int N_LANES = 4,
  parameter int TS_W    = 16,
  parameter int LANE_W  = 2,
  parameter bit SPREAD  = 1'b1
) (
  input  logic [LANE_W-1:0]       cur,
  input  logic [TS_W-1:0]         prev_ts,
  input  logic [TS_W-1:0]         ts,
  input  logic [N_LANES-1:0]      full,
  input  logic [N_LANES-1:0]      nempty,
  input  logic [N_LANES*TS_W-1:0] last_ts,
  output logic [LANE_W-1:0]       dest,
  output sel_e                    decision
);

  logic              rising, advance, conflict;
  logic [LANE_W-1:0] nxt;
  logic [TS_W-1:0]   dest_last;

  always_comb begin
    rising  = ts > prev_ts;
    nxt     = (int'(cur) == N_LANES - 1) ? '0 : cur + LANE_W'(1);
    advance = !rising;
    if (SPREAD) advance = advance || full[cur];
    dest      = advance ? nxt : cur;
    dest_last = last_ts[int'(dest)*TS_W +: TS_W];
    // the ordering check outranks the room check
    conflict  = nempty[dest] && (dest_last > ts);
    if (conflict)        decision = SEL_REJECT;
    else if (full[dest]) decision = SEL_STALL;
    else                 decision = SEL_STORE;
  end

endmodule

// File: rtl/evlane_dist.sv
module evlane_dist
  import evlane_pkg::*;
#(
  parameter int N_LANES = 4,
  parameter int DEPTH   = 4,
  parameter int TS_W    = 16,
  parameter int CH_W    = 4,
  parameter int AD_W    = 4,
  parameter int DT_W    = 8,
  parameter bit SPREAD  = 1'b1,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int SEQ_W  = evlane_pkg::seq_bits(N_LANES, DEPTH),
  localparam int ENT_W  = SEQ_W + CH_W + AD_W + TS_W + DT_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [TS_W-1:0]            in_ts,
  input  logic [CH_W-1:0]            in_chan,
  input  logic [AD_W-1:0]            in_addr,
  input  logic [DT_W-1:0]            in_data,
  input  logic                       err_clr,
  output logic                       seq_err,
  input  logic [N_LANES-1:0]         lane_pop,
  output logic [N_LANES-1:0]         lane_nempty,
  output logic [N_LANES*LVL_W-1:0]   lane_level,
  output logic [N_LANES*ENT_W-1:0]   lane_head
);

  localparam int LANE_W = (N_LANES > 1) ? $clog2(N_LANES) : 1;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  // state
  logic [LANE_W-1:0] cur_q, cur_d;
  logic [TS_W-1:0]   prev_q, prev_d;
  logic [TS_W-1:0]   last_q [N_LANES];
  logic [SEQ_W-1:0]  seq_q, seq_d;
  logic              err_q, err_d;

  logic [N_LANES*TS_W-1:0] last_flat;
  logic [N_LANES-1:0]      lane_full;
  logic [N_LANES-1:0]      lane_push;
  logic [LANE_W-1:0]       dest;
  sel_e                    decision;
  logic                    store, err_set;
  logic [ENT_W-1:0]        wentry;

  evlane_sel #(
    .N_LANES(N_LANES),
    .TS_W   (TS_W),
    .LANE_W (LANE_W),
    .SPREAD (SPREAD)
  ) u_sel (
    .cur     (cur_q),
    .prev_ts (prev_q),
    .ts      (in_ts),
    .full    (lane_full),
    .nempty  (lane_nempty),
    .last_ts (last_flat),
    .dest    (dest),
    .decision(decision)
  );

  // next state
  always_comb begin
    store   = in_valid && (decision == SEL_STORE);
    err_set = in_valid && (decision == SEL_REJECT);
    cur_d   = dest;
    prev_d  = in_ts;
    seq_d   = seq_q + SEQ_W'(1);
    if (err_set)      err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
    else              err_d = err_q;
  end

  assign in_ready = (decision != SEL_STALL);
  assign seq_err  = err_q;
  assign wentry   = {seq_q, in_chan, in_addr, in_ts, in_data};

  // registers, with the store enable written out
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cur_q  <= '0;
      prev_q <= '0;
      seq_q  <= '0;
    end else if (store) begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
      seq_q  <= seq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) err_q <= 1'b0;
    else          err_q <= err_d;
  end

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    assign lane_push[i] = store && (int'(dest) == i);
    assign last_flat[i*TS_W +: TS_W] = last_q[i];

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n)          last_q[i] <= '0;
      else if (lane_push[i]) last_q[i] <= in_ts;
    end

    evlane_fifo #(
      .DEPTH(DEPTH),
      .W    (ENT_W)
    ) u_fifo (
      .clk   (clk),
      .rst_n (rst_q_n),
      .push  (lane_push[i]),
      .pop   (lane_pop[i]),
      .wdata (wentry),
      .rdata (lane_head[i*ENT_W +: ENT_W]),
      .full  (lane_full[i]),
      .nempty(lane_nempty[i]),
      .level (lane_level[i*LVL_W +: LVL_W])
    );
  end

endmodule

// File: rtl/evlane_dist_chk.sv
module evlane_dist_chk #(
  parameter int N_LANES = 4,
  parameter int SEQ_W   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               err_clr,
  input logic               seq_err,
  input logic               err_set,
  input logic [N_LANES-1:0] lane_push,
  input logic [N_LANES-1:0] lane_full,
  input logic [SEQ_W-1:0]   seq_q
);

  // R6
  stall_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (lane_push == '0));

  // R2
  one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_push));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_push & lane_full) == '0);

  // R5
  reject_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |-> (lane_push == '0) && in_ready);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err && !err_clr) |=> seq_err);

  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> seq_err);

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !err_set) |=> !seq_err);

  // R7
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_push != '0) |=> (seq_q == $past(seq_q) + SEQ_W'(1)));

  // R7
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_push == '0) |=> $stable(seq_q));

endmodule

bind evlane_dist evlane_dist_chk #(
  .N_LANES(N_LANES),
  .SEQ_W  (SEQ_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .err_clr  (err_clr),
  .seq_err  (seq_err),
  .err_set  (err_set),
  .lane_push(lane_push),
  .lane_full(lane_full),
  .seq_q    (seq_q)
);

// File: tb/test_evlane_dist.sv
module test_evlane_dist;

  localparam int N     = 4;
  localparam int D     = 4;
  localparam int TS_W  = 16;
  localparam int CH_W  = 4;
  localparam int AD_W  = 4;
  localparam int DT_W  = 8;
  localparam bit SPR   = 1'b1;
  localparam int LVL_W = $clog2(D + 1);
  localparam int SEQ_W = $clog2(N * D + 1) + 2;
  localparam int ENT_W = SEQ_W + CH_W + AD_W + TS_W + DT_W;
  localparam int NCYC  = 4000;
  localparam int NDIR  = 15;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   in_valid;
  logic                   in_ready;
  logic [TS_W-1:0]        in_ts;
  logic [CH_W-1:0]        in_chan;
  logic [AD_W-1:0]        in_addr;
  logic [DT_W-1:0]        in_data;
  logic                   err_clr;
  logic                   seq_err;
  logic [N-1:0]           lane_pop;
  logic [N-1:0]           lane_nempty;
  logic [N*LVL_W-1:0]     lane_level;
  logic [N*ENT_W-1:0]     lane_head;

  always #2ns clk = ~clk;

  evlane_dist #(
    .N_LANES(N), .DEPTH(D), .TS_W(TS_W), .CH_W(CH_W),
    .AD_W(AD_W), .DT_W(DT_W), .SPREAD(SPR)
  ) i_evlane_dist (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ts(in_ts), .in_chan(in_chan), .in_addr(in_addr), .in_data(in_data),
    .err_clr(err_clr), .seq_err(seq_err), .lane_pop(lane_pop),
    .lane_nempty(lane_nempty), .lane_level(lane_level), .lane_head(lane_head)
  );

  int n_tot = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference model
  logic [ENT_W-1:0] mbuf [N][D];
  int               mhd  [N];
  int               mcnt [N];
  logic [TS_W-1:0]  mlast[N];
  logic [TS_W-1:0]  mprev;
  int               mcur;
  logic [SEQ_W-1:0] mseq;
  bit               merr;

  // pending submitter event
  bit              pv;
  logic [TS_W-1:0] pts;
  logic [CH_W-1:0] pch;
  logic [AD_W-1:0] pad;
  logic [DT_W-1:0] pdt;
  int              gts;
  int              didx;
  int              dir_ts [NDIR] = '{10, 20, 5, 3, 1, 0, 2, 3, 4, 30, 40, 50, 60, 70, 8};

  // prediction
  int  p_dest;
  int  p_dec;   // 0 store, 1 stall, 2 reject

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic predict();
    bit rising, adv;
    rising = pts > mprev;
    adv    = !rising || (SPR && mcnt[mcur] == D);
    p_dest = adv ? (mcur + 1) % N : mcur;
    if (mcnt[p_dest] > 0 && mlast[p_dest] > pts) p_dec = 2;
    else if (mcnt[p_dest] == D)                  p_dec = 1;
    else                                         p_dec = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; in_valid = 1'b0; in_ts = '0; in_chan = '0; in_addr = '0;
    in_data = '0; err_clr = 1'b0; lane_pop = '0;
    for (int i = 0; i < N; i++) begin
      mhd[i] = 0; mcnt[i] = 0; mlast[i] = '0;
    end
    mprev = '0; mcur = 0; mseq = '0; merr = 1'b0;
    pv = 1'b0; gts = 0; didx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: empty lanes, error low
    chk(lane_nempty == '0, "R1 nempty after reset", 64'(lane_nempty), 0);
    chk(lane_level == '0, "R1 level after reset", 64'(lane_level), 0);
    chk(seq_err == 1'b0, "R1 seq_err after reset", 64'(seq_err), 0);

    for (int c = 0; c < NCYC; c++) begin
      int  pop_pct;
      bit  eclr;
      if (c > 0) @(negedge clk);
      if (!pv && (didx < NDIR || $urandom_range(0, 5) != 0)) begin
        if (didx < NDIR) begin
          gts = dir_ts[didx];
          didx++;
        end else begin
          gts = gts + $urandom_range(0, 7) - 2;
          if (gts < 0) gts = 0;
          if (gts > 65535) gts = 65535;
        end
        pts = TS_W'(gts);
        pch = CH_W'($urandom);
        pad = AD_W'($urandom);
        pdt = DT_W'($urandom);
        pv  = 1'b1;
      end
      in_valid = pv;
      in_ts = pts; in_chan = pch; in_addr = pad; in_data = pdt;
      eclr = ($urandom_range(0, 11) == 0);
      err_clr = eclr;
      if (c < 30)              pop_pct = 0;
      else if ((c % 800) < 400) pop_pct = 10;
      else                     pop_pct = 50;
      for (int i = 0; i < N; i++)
        lane_pop[i] = ($urandom_range(0, 99) < pop_pct);
      #1;
      predict();
      // R9: level and not-empty per lane; R8: error flag
      for (int i = 0; i < N; i++) begin
        chk(int'(lane_level[i*LVL_W +: LVL_W]) == mcnt[i], "R9 level",
            64'(lane_level[i*LVL_W +: LVL_W]), 64'(mcnt[i]));
        chk(lane_nempty[i] == (mcnt[i] > 0), "R9 nempty",
            64'(lane_nempty[i]), 64'(mcnt[i] > 0));
        if (lane_pop[i] && mcnt[i] > 0)
          // R9 order; head word also checks R7 numbering and R2 R3 R4 lane choice
          chk(lane_head[i*ENT_W +: ENT_W] == mbuf[i][mhd[i]], "R9 head R7 R2 R3 R4",
              64'(lane_head[i*ENT_W +: ENT_W]), 64'(mbuf[i][mhd[i]]));
      end
      chk(seq_err == merr, "R8 seq_err", 64'(seq_err), 64'(merr));
      if (pv) begin
        if (p_dec == 2 && mcnt[p_dest] == D)
          chk(in_ready == 1'b1, "R10 reject on full lane", 64'(in_ready), 1);
        else if (p_dec == 2)
          chk(in_ready == 1'b1, "R5 reject ready", 64'(in_ready), 1);
        else if (p_dec == 1)
          chk(in_ready == 1'b0, "R6 stall", 64'(in_ready), 0);
        else
          chk(in_ready == 1'b1, "R2 store ready", 64'(in_ready), 1);
      end
      @(posedge clk);
      // model update at the edge
      begin
        bit eset;
        eset = 1'b0;
        for (int i = 0; i < N; i++)
          if (lane_pop[i] && mcnt[i] > 0) begin
            mhd[i]  = (mhd[i] + 1) % D;
            mcnt[i] = mcnt[i] - 1;
          end
        if (pv) begin
          if (p_dec == 2) begin
            eset = 1'b1;
            pv   = 1'b0;
          end else if (p_dec == 0) begin
            mbuf[p_dest][(mhd[p_dest] + mcnt[p_dest]) % D] = {mseq, pch, pad, pts, pdt};
            mcnt[p_dest] = mcnt[p_dest] + 1;
            mlast[p_dest] = pts;
            mprev = pts;
            mcur  = p_dest;
            mseq  = mseq + SEQ_W'(1);
            pv    = 1'b0;
          end
        end
        if (eset)      merr = 1'b1;
        else if (eclr) merr = 1'b0;
      end
    end
    @(negedge clk);
    chk(seq_err == merr, "R8 final seq_err", 64'(seq_err), 64'(merr));
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tot++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

endmodule